// File: doc/BRIEF.md
# Spanning-Tree Instance State Table

This block keeps one record for each spanning-tree instance. Each record is a valid flag and a two-bit forwarding state for every switch port. A record is selected by a six-bit instance number. A host reaches the table through a small register window: an instance-number register, a result/valid register, a set of packed port-state data registers and a command register. Three commands are available. Load/purge writes or removes one instance. Get-next scans upward for the next valid instance. Flush invalidates every instance.

The table has no direct exact-match read. To look up instance n, the host issues get-next starting from n-1 (modulo 64). The result is a hit only when the returned instance number equals n and the valid bit is set. A start value of all-ones makes the scan begin at instance 0, so a full walk starts there. A command runs in the background while the busy bit is set. The host polls that bit before it touches the window again.

The controller is a four-state machine. `ST_IDLE` waits for a command. `ST_FLUSH` clears every valid flag in one cycle. `ST_LOAD` writes or purges one record in one cycle. `ST_SCAN` tests one instance per cycle, starting at the start value plus one. The transitions are:
- `ST_IDLE` moves to `ST_FLUSH`, `ST_LOAD` or `ST_SCAN` on a command.
- `ST_FLUSH` and `ST_LOAD` always return to `ST_IDLE`.
- `ST_SCAN` returns to `ST_IDLE` on a hit or after it has tested instance 63. Otherwise it stays in `ST_SCAN` and advances by one instance.

Top module: `stu_state_table`

## Requirements
- R1: After reset, every register in the window reads zero, busy is low and no instance is valid: a get-next from start 63 finds nothing.
- R2: The instance-number register (address 1) keeps only bits 5:0 of a write. Bits 15:6 always read zero.
- R3: The command register is at address 0. Bit 15 is go/busy and bits 14:12 are the opcode: 1 = flush, 3 = load/purge, 5 = get-next. A write with bit 15 set and a listed opcode sets busy, which reads 1 in the next cycle. A write with bit 15 clear, or with an unlisted opcode, starts nothing. Register writes made while busy is set are ignored.
- R4: Load/purge acts on the instance held in address 1. When bit 12 of the valid register (address 2) is 1, the instance becomes valid with the current port states. When that bit is 0, the instance is made invalid.
- R5: The state of port i sits at bits (i mod 8)*2+1 : (i mod 8)*2 of data register i/8. Data register 0 is at address 3 and data register 1 is at address 4.
- R6: Get-next returns the smallest valid instance number strictly greater than the start value, with the valid bit at 1 and the data registers holding that instance's states. A start value of 63 scans from instance 0.
- R7: When get-next finds no valid instance, the instance number reads 63, the valid bit reads 0 and the data registers read zero.
- R8: A flush leaves every instance invalid.
- R9: Busy clears within 65 cycles (the table depth plus one) after the command write.
- R10: An exact lookup of instance n, done as get-next from n-1 (modulo 64), returns n with the valid bit set exactly when n is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational read data for cfg_addr |

## Verification
The assertions assume that the host writes to the window only through cfg_wr. They also assume that any register-write check made during busy concerns a load or flush command, because a scan overwrites the instance register when it finishes. The stimulus follows a poll-until-idle discipline. It deliberately writes during busy only in the directed test for ignored writes. Random commands draw instance numbers, valid bits and port states from a seeded generator, and are mixed with directed scans across both ends of the instance range.

// File: rtl/stu_pkg.sv
package stu_pkg;
    localparam int REG_W   = 16;
    localparam int GO_BIT  = 15;
    localparam int VLD_BIT = 12;

    localparam logic [2:0] OPC_FLUSH = 3'd1;
    localparam logic [2:0] OPC_LOAD  = 3'd3;
    localparam logic [2:0] OPC_NEXT  = 3'd5;

    localparam logic [2:0] A_CMD   = 3'd0;
    localparam logic [2:0] A_SID   = 3'd1;
    localparam logic [2:0] A_VLD   = 3'd2;
    localparam logic [2:0] A_DATA0 = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_SCAN  = 2'd3
    } fsm_e;
endpackage

// File: rtl/stu_entry_store.sv
module stu_entry_store #(
    parameter int SID_W = 6,
    parameter int ST_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_all,
    input  logic                  wr_en,
    input  logic [SID_W-1:0]      wr_sid,
    input  logic                  wr_valid,
    input  logic [ST_W-1:0]       wr_states,
    input  logic [SID_W-1:0]      rd_sid,
    output logic                  rd_valid,
    output logic [ST_W-1:0]       rd_states,
    output logic [(1<<SID_W)-1:0] vld_vec
);
    localparam int DEPTH = 1 << SID_W;

    logic [ST_W-1:0] st_mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit_e;
        assign hit_e = wr_en && (wr_sid == SID_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_vec[e] <= 1'b0;
            end else if (clr_all) begin
                vld_vec[e] <= 1'b0;
            end else if (hit_e) begin
                vld_vec[e] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_e && wr_valid) begin
                st_mem[e] <= wr_states;
            end
        end
    end

    assign rd_valid  = vld_vec[rd_sid];
    assign rd_states = st_mem[rd_sid];
endmodule

// File: rtl/stu_cmd_fsm.sv
module stu_cmd_fsm
    import stu_pkg::*;
#(
    parameter int SID_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       start_op,
    input  logic [SID_W-1:0] cfg_sid,
    input  logic             rd_valid,
    output logic             busy,
    output logic [SID_W-1:0] ptr,
    output logic             store_wr,
    output logic             store_clr,
    output logic             res_we,
    output logic             res_hit,
    output logic [SID_W-1:0] res_sid
);
    localparam logic [SID_W-1:0] SID_MAX = '1;

    fsm_e             state_q, state_d;
    logic [SID_W-1:0] ptr_q, ptr_d;
    logic             scan_end;

    assign scan_end = rd_valid || (ptr_q == SID_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    case (start_op)
                        OPC_FLUSH: state_d = ST_FLUSH;
                        OPC_LOAD:  state_d = ST_LOAD;
                        OPC_NEXT: begin
                            state_d = ST_SCAN;
                            ptr_d   = cfg_sid + SID_W'(1);
                        end
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_FLUSH: state_d = ST_IDLE;
            ST_LOAD:  state_d = ST_IDLE;
            ST_SCAN: begin
                if (scan_end) begin
                    state_d = ST_IDLE;
                end else begin
                    ptr_d = ptr_q + SID_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        ptr       = ptr_q;
        store_wr  = (state_q == ST_LOAD);
        store_clr = (state_q == ST_FLUSH);
        res_we    = (state_q == ST_SCAN) && scan_end;
        res_hit   = (state_q == ST_SCAN) && rd_valid;
        res_sid   = rd_valid ? ptr_q : SID_MAX;
    end
endmodule

// File: rtl/stu_host_regs.sv
module stu_host_regs
    import stu_pkg::*;
#(
    parameter int SID_W = 6,
    parameter int NREG  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [2:0]            cfg_addr,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic [REG_W-1:0]      cfg_rdata,
    input  logic                  busy,
    input  logic                  res_we,
    input  logic                  res_hit,
    input  logic [SID_W-1:0]      res_sid,
    input  logic [NREG*REG_W-1:0] res_data,
    output logic                  start,
    output logic [2:0]            start_op,
    output logic [SID_W-1:0]      sid_q,
    output logic                  vld_q,
    output logic [NREG*REG_W-1:0] data_q,
    output logic [2:0]            op_q
);
    logic wr_ok;
    logic op_legal;

    assign start_op = cfg_wdata[14:12];
    assign op_legal = (start_op == OPC_FLUSH) || (start_op == OPC_LOAD) ||
                      (start_op == OPC_NEXT);
    assign wr_ok    = cfg_wr && !busy;
    assign start    = wr_ok && (cfg_addr == A_CMD) && cfg_wdata[GO_BIT] && op_legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sid_q  <= '0;
            vld_q  <= 1'b0;
            data_q <= '0;
            op_q   <= '0;
        end else if (res_we) begin
            sid_q  <= res_sid;
            vld_q  <= res_hit;
            data_q <= res_hit ? res_data : '0;
        end else if (wr_ok) begin
            if (cfg_addr == A_SID) sid_q <= cfg_wdata[SID_W-1:0];
            if (cfg_addr == A_VLD) vld_q <= cfg_wdata[VLD_BIT];
            for (int r = 0; r < NREG; r++) begin
                if (cfg_addr == 3'(int'(A_DATA0) + r)) begin
                    data_q[r*REG_W +: REG_W] <= cfg_wdata;
                end
            end
            if (start) op_q <= start_op;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == A_CMD) begin
            cfg_rdata[GO_BIT] = busy;
            cfg_rdata[14:12]  = op_q;
        end
        if (cfg_addr == A_SID) cfg_rdata[SID_W-1:0] = sid_q;
        if (cfg_addr == A_VLD) cfg_rdata[VLD_BIT] = vld_q;
        for (int r = 0; r < NREG; r++) begin
            if (cfg_addr == 3'(int'(A_DATA0) + r)) begin
                cfg_rdata = data_q[r*REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/stu_state_table.sv
module stu_state_table
    import stu_pkg::*;
#(
    parameter int SID_W  = 6,
    parameter int NPORTS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata
);
    localparam int DEPTH  = 1 << SID_W;
    localparam int NREG   = (NPORTS + 7) / 8;
    localparam int ST_W   = 2 * NPORTS;
    localparam int DATA_W = NREG * REG_W;

    logic                  start;
    logic [2:0]            start_op;
    logic [SID_W-1:0]      sid_q;
    logic                  vld_q;
    logic [DATA_W-1:0]     data_q;
    logic [2:0]            op_q;
    logic                  busy;
    logic [SID_W-1:0]      ptr;
    logic                  store_wr, store_clr;
    logic                  res_we, res_hit;
    logic [SID_W-1:0]      res_sid;
    logic                  rd_valid;
    logic [ST_W-1:0]       rd_states;
    logic [DEPTH-1:0]      vld_vec;
    logic [DATA_W-1:0]     res_data;

    always_comb begin
        res_data           = '0;
        res_data[ST_W-1:0] = rd_states;
    end

    stu_host_regs #(.SID_W(SID_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .res_we(res_we), .res_hit(res_hit), .res_sid(res_sid), .res_data(res_data),
        .start(start), .start_op(start_op), .sid_q(sid_q), .vld_q(vld_q), .data_q(data_q),
        .op_q(op_q)
    );

    stu_cmd_fsm #(.SID_W(SID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op), .cfg_sid(sid_q),
        .rd_valid(rd_valid), .busy(busy), .ptr(ptr), .store_wr(store_wr),
        .store_clr(store_clr), .res_we(res_we), .res_hit(res_hit), .res_sid(res_sid)
    );

    stu_entry_store #(.SID_W(SID_W), .ST_W(ST_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_all(store_clr), .wr_en(store_wr), .wr_sid(sid_q),
        .wr_valid(vld_q), .wr_states(data_q[ST_W-1:0]), .rd_sid(ptr), .rd_valid(rd_valid),
        .rd_states(rd_states), .vld_vec(vld_vec)
    );
endmodule

// File: rtl/stu_state_table_chk.sv
module stu_state_table_chk
    import stu_pkg::*;
#(
    parameter int SID_W = 6,
    parameter int NREG  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr,
    input logic [2:0]            cfg_addr,
    input logic [15:0]           cfg_wdata,
    input logic [15:0]           cfg_rdata,
    input logic                  busy,
    input logic [SID_W-1:0]      sid_q,
    input logic                  vld_q,
    input logic [NREG*16-1:0]    data_q,
    input logic [2:0]            op_q,
    input logic [(1<<SID_W)-1:0] vld_vec
);
    localparam int DEPTH = 1 << SID_W;

    logic [SID_W+1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= (SID_W+2)'(DEPTH)));

    assert_sid_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == A_SID) |-> (cfg_rdata[15:SID_W] == '0));

    assert_go_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_wr && cfg_addr == A_CMD && cfg_wdata[GO_BIT] &&
         (cfg_wdata[14:12] == OPC_FLUSH || cfg_wdata[14:12] == OPC_LOAD ||
          cfg_wdata[14:12] == OPC_NEXT)) |=> busy);

    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && cfg_addr == A_SID && op_q != OPC_NEXT) |=> $stable(sid_q));

    assert_miss_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OPC_NEXT && $fell(busy) && !vld_q) |-> (sid_q == '1 && data_q == '0));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OPC_FLUSH && $fell(busy)) |-> (vld_vec == '0));
endmodule

bind stu_state_table stu_state_table_chk #(.SID_W(SID_W), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .busy(busy), .sid_q(sid_q), .vld_q(vld_q), .data_q(data_q),
    .op_q(op_q), .vld_vec(vld_vec)
);

// File: tb/test_stu_state_table.sv
module test_stu_state_table;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    bit          m_vld [DEPTH];
    logic [31:0] m_st  [DEPTH];
    logic [31:0] cur_data;
    bit          cur_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    stu_state_table i_stu_state_table (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic do_op(input logic [2:0] opc);
        int cyc;
        logic [15:0] r;
        reg_wr(3'd0, {1'b1, opc, 12'd0});
        cyc = 0;
        for (int k = 0; k < 1000; k++) begin
            reg_rd(3'd0, r);
            if (!r[15]) break;
            cyc++;
            @(negedge clk);
        end
        chk("R9 busy cycles", (cyc <= DEPTH + 1) ? 32'd1 : 32'd0, 32'd1);
    endtask

    function automatic int exp_next(input int start);
        int s0;
        s0 = (start == DEPTH - 1) ? 0 : start + 1;
        for (int s = s0; s < DEPTH; s++) if (m_vld[s]) return s;
        return -1;
    endfunction

    task automatic set_fields(input int sid, input bit v, input logic [31:0] st);
        reg_wr(3'd1, 16'(sid));
        reg_wr(3'd2, v ? 16'h1000 : 16'h0000);
        reg_wr(3'd3, st[15:0]);
        reg_wr(3'd4, st[31:16]);
        cur_vld = v; cur_data = st;
    endtask

    task automatic load(input int sid, input bit v, input logic [31:0] st);
        set_fields(sid, v, st);
        do_op(3'd3);
        m_vld[sid] = v;
        if (v) m_st[sid] = st;
    endtask

    task automatic getnext(input int start, output logic [15:0] s, output logic [15:0] v,
                           output logic [31:0] d);
        logic [15:0] lo, hi;
        reg_wr(3'd1, 16'(start));
        do_op(3'd5);
        reg_rd(3'd1, s); reg_rd(3'd2, v); reg_rd(3'd3, lo); reg_rd(3'd4, hi);
        d = {hi, lo};
    endtask

    task automatic gn_check(input int start, input string tag);
        logic [15:0] s, v;
        logic [31:0] d;
        int e;
        getnext(start, s, v, d);
        e = exp_next(start);
        if (e < 0) begin
            chk({tag, " R7 miss sid"}, 32'(s), 32'd63);
            chk({tag, " R7 miss valid"}, 32'(v), 32'd0);
            chk({tag, " R7 miss data"}, d, 32'd0);
        end else begin
            chk({tag, " R6 next sid"}, 32'(s), 32'(e));
            chk({tag, " R6 next valid"}, 32'(v), 32'h1000);
            chk({tag, " R6 next data"}, d, m_st[e]);
        end
    endtask

    task automatic lookup(input int n);
        logic [15:0] s, v;
        logic [31:0] d;
        getnext((n + DEPTH - 1) % DEPTH, s, v, d);
        chk("R10 exact lookup hit", ((32'(s) == 32'(n)) && v[12]) ? 32'd1 : 32'd0,
            m_vld[n] ? 32'd1 : 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_st[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), r);
            chk("R1 reset reg", 32'(r), 32'd0);
        end
        gn_check(63, "R1");

        // R2 SID mask
        reg_wr(3'd1, 16'hFFFF);
        reg_rd(3'd1, r);
        chk("R2 sid mask", 32'(r), 32'h003F);

        // R5 packing: port 9 state 2 -> data reg 1 bits 3:2; port 0 state 3 -> data reg 0 bits 1:0
        load(5, 1, 32'h0008_0003);
        load(10, 1, 32'hA5A5_5A5A);
        load(63, 1, 32'h1234_FEDC);
        begin
            logic [15:0] s, v;
            logic [31:0] d;
            getnext(4, s, v, d);
            chk("R5 port9 in data reg1", 32'(d[31:16]), 32'h0008);
            chk("R5 port0 in data reg0", 32'(d[15:0]), 32'h0003);
        end

        // R6 directed scans including wrap start
        gn_check(0, "R6 a");
        gn_check(5, "R6 b");
        gn_check(10, "R6 c");
        gn_check(63, "R6 wrap");
        gn_check(62, "R6 top");

        // R4 purge
        load(10, 0, 32'h0);
        gn_check(9, "R4 purge");
        lookup(10);
        lookup(5);

        // R3 go bit clear starts nothing
        reg_wr(3'd0, 16'h3000);
        reg_rd(3'd0, r);
        chk("R3 no go no busy", 32'(r[15]), 32'd0);
        // R3 unlisted opcode starts nothing
        reg_wr(3'd0, 16'hF000);
        reg_rd(3'd0, r);
        chk("R3 bad opcode no busy", 32'(r[15]), 32'd0);

        // R3 busy then ignored write
        set_fields(20, 1, 32'h0F0F_0F0F);
        reg_wr(3'd0, 16'hB000);
        reg_rd(3'd0, r);
        chk("R3 busy after go", 32'(r[15]), 32'd1);
        reg_wr(3'd1, 16'd7);
        reg_rd(3'd1, r);
        chk("R3 write while busy ignored", 32'(r), 32'd20);
        m_vld[20] = 1; m_st[20] = 32'h0F0F_0F0F;
        lookup(20);
        lookup(7);

        // long scan: only 63 valid from start 63 -> wraps from 0
        do_op(3'd1);
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
        gn_check(63, "R8 after flush");
        load(63, 1, 32'hCAFE_0001);
        gn_check(63, "R9 longest scan");

        // random mix
        for (int it = 0; it < 220; it++) begin
            int sel, sid;
            sel = int'($urandom_range(0, 19));
            sid = int'($urandom_range(0, DEPTH - 1));
            if (sel < 9)       load(sid, 1, $urandom);
            else if (sel < 12) load(sid, 0, $urandom);
            else if (sel < 16) gn_check(sid, "R6 rand");
            else if (sel < 19) lookup(sid);
            else begin
                do_op(3'd1);
                for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
                gn_check(63, "R8 rand flush");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule